// File: doc/BRIEF.md
# Frame-Synchronized Configuration Register Bank

This block holds the configuration words of a display compositor in pairs. Software writes a working ("base") copy of each word over a simple register bus. The hardware uses a separate active ("shadow") copy. The shadow copies are loaded from the base copies all at once, and only on the rising edge of the vertical sync pulse from the timing generator. The load happens only when two conditions hold: a global sync-enable bit must be set, and a one-shot layer-update request must be pending. Software clears sync enable, rewrites a group of words, then sets sync enable together with the update request. A half-finished group can therefore never reach the active copies.

Both copies of every pair can be read back. A pair counts as settled when its base and shadow values are equal. Each vsync edge also sets an interrupt status bit. That bit is read in one position of the interrupt register and cleared by writing a different bit of the same register. A separate enable bit masks the interrupt output. A frame-event pulse follows each vsync edge. In interlaced operation that pulse is suppressed while any pair is out of step or an update is still pending. A run bit and an idle status bit signal when the engine has stopped at a frame boundary.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset every base and shadow word is 0, `irq` is 0, and the control register (address 0x00) reads 0x08: only idle is set.
- R2: A write to address 0x10+i (i < NUM_REGS) updates base word i, which reads back at 0x10+i; the shadow word at 0x20+i is unchanged by the write.
- R3: All shadow words load from their base words together, in the one cycle after a rising vsync edge is seen while control bit 1 (sync enable) and control bit 2 (update request) are both 1. At any other time the shadows hold.
- R4: Writing 1 to control bit 2 sets the update request. A transfer clears it. Writing 0 to that bit has no effect, and the request stays set across vsync edges while sync enable is 0.
- R5: A base write in the same cycle as a transfer changes only the base word. The shadow takes the previous base value, and the new value moves to the shadow at the next transfer.
- R6: Interrupt register (address 0x01) bit 4 (status) sets on every rising vsync edge, whatever the enable. `irq` is high exactly when status and bit 0 (enable, read/write) are both 1.
- R7: Writing 1 to interrupt register bit 8 clears the status. Bit 8 always reads 0. A rising vsync edge in the same cycle as a clear leaves the status set.
- R8: `vblank_evt` pulses for one cycle, one cycle after a rising vsync edge. When control bit 4 (interlace) is 1, the pulse appears only if every pair matches and no update request is pending.
- R9: Control bit 0 (run) is read/write. Control bit 3 (idle) goes low while run is 1. After run is cleared, idle goes high at the next rising vsync edge.
- R10: Reading an unmapped address returns 0. Writes to shadow addresses and unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | Vertical sync level from the timing generator |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Register address; bits 5:4 select the region, bits 3:0 the index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| shadow_o | output | NUM_REGS*DATA_W | Active copies, word i at bits i*DATA_W upward |
| irq | output | 1 | Vsync interrupt (status AND enable) |
| vblank_evt | output | 1 | One-cycle frame event after a vsync edge |

## Verification
The hardest cases to reach are coincidences at one clock edge: a base write landing on the very cycle a transfer fires, and an interrupt clear landing on a vsync edge. The stimulus drives vsync and the bus from the same per-cycle task, so both events can be placed deliberately in one cycle. A random phase then adds many more such collisions. The interlaced event suppression is reached by leaving a pair mismatched with sync enable off and then pulsing vsync. The behavioural model tracks every collision and is compared on every clock.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
    localparam logic [1:0] REGION_CSR    = 2'b00;
    localparam logic [1:0] REGION_BASE   = 2'b01;
    localparam logic [1:0] REGION_SHADOW = 2'b10;

    localparam logic [3:0] CSR_CTRL = 4'd0;
    localparam logic [3:0] CSR_INT  = 4'd1;

    localparam int CTL_RUN  = 0;
    localparam int CTL_SYNC = 1;
    localparam int CTL_UPD  = 2;
    localparam int CTL_IDLE = 3;
    localparam int CTL_INTL = 4;

    localparam int IRQ_EN   = 0;
    localparam int IRQ_STAT = 4;
    localparam int IRQ_CLR  = 8;

    typedef struct packed {
        logic run;
        logic sync_en;
        logic upd;
        logic intl;
        logic idle;
        logic vs_prev;
        logic evt_pend;
    } ctl_state_t;

    typedef struct packed {
        logic en;
        logic stat;
    } irq_state_t;
endpackage

// File: rtl/vsb_ctl.sv
module vsb_ctl
    import vsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic wr_ctrl,
    input  logic wr_run,
    input  logic wr_sync,
    input  logic wr_upd,
    input  logic wr_intl,
    output logic run,
    output logic sync_en,
    output logic upd,
    output logic intl,
    output logic idle,
    output logic vs_rise,
    output logic xfer,
    output logic evt_pend
);
    ctl_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        vs_rise  = vsync & ~s_q.vs_prev;
        xfer     = vs_rise & s_q.sync_en & s_q.upd;

        s_d.vs_prev  = vsync;
        s_d.evt_pend = vs_rise;

        if (xfer) s_d.upd = 1'b0;
        if (wr_ctrl) begin
            s_d.run     = wr_run;
            s_d.sync_en = wr_sync;
            s_d.intl    = wr_intl;
            if (wr_upd) s_d.upd = 1'b1;
        end

        if (s_q.run)      s_d.idle = 1'b0;
        else if (vs_rise) s_d.idle = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.idle <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign run      = s_q.run;
    assign sync_en  = s_q.sync_en;
    assign upd      = s_q.upd;
    assign intl     = s_q.intl;
    assign idle     = s_q.idle;
    assign evt_pend = s_q.evt_pend;
endmodule

// File: rtl/vsb_irq.sv
module vsb_irq
    import vsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vs_rise,
    input  logic wr_int,
    input  logic wr_en_bit,
    input  logic wr_clr_bit,
    output logic stat,
    output logic en,
    output logic irq
);
    irq_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_int) r_d.en = wr_en_bit;
        if (vs_rise)                   r_d.stat = 1'b1;
        else if (wr_int && wr_clr_bit) r_d.stat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat = r_q.stat;
    assign en   = r_q.en;
    assign irq  = r_q.stat & r_q.en;
endmodule

// File: rtl/vsb_pairs.sv
module vsb_pairs #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_base,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         xfer,
    output logic [NUM_REGS*DATA_W-1:0]   base_flat,
    output logic [NUM_REGS*DATA_W-1:0]   shadow_flat,
    output logic                         all_match
);
    logic [NUM_REGS-1:0][DATA_W-1:0] base_d, base_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] shadow_d, shadow_q;
    logic [NUM_REGS-1:0]             pair_eq;

    always_comb begin
        base_d   = base_q;
        shadow_d = xfer ? base_q : shadow_q;
        if (wr_base) base_d[wr_idx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            shadow_q <= '0;
        end else begin
            base_q   <= base_d;
            shadow_q <= shadow_d;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_pair
        assign pair_eq[i]                         = (base_q[i] == shadow_q[i]);
        assign base_flat[i*DATA_W +: DATA_W]      = base_q[i];
        assign shadow_flat[i*DATA_W +: DATA_W]    = shadow_q[i];
    end

    assign all_match = &pair_eq;
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank
    import vsb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vsync,
    input  logic                       bus_wr,
    input  logic [5:0]                 bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_REGS*DATA_W-1:0] shadow_o,
    output logic                       irq,
    output logic                       vblank_evt
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [1:0] region;
    logic [3:0] idx;
    logic       idx_ok;
    logic       wr_base, wr_ctrl, wr_int;
    logic       run, sync_en, upd, intl, idle, vs_rise, xfer, evt_pend;
    logic       stat, en;
    logic       all_match;
    logic [NUM_REGS*DATA_W-1:0] base_flat;

    assign region  = bus_addr[5:4];
    assign idx     = bus_addr[3:0];
    assign idx_ok  = ({28'd0, idx} < NUM_REGS);
    assign wr_base = bus_wr && (region == REGION_BASE) && idx_ok;
    assign wr_ctrl = bus_wr && (region == REGION_CSR) && (idx == CSR_CTRL);
    assign wr_int  = bus_wr && (region == REGION_CSR) && (idx == CSR_INT);

    vsb_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (vsync),
        .wr_ctrl  (wr_ctrl),
        .wr_run   (bus_wdata[CTL_RUN]),
        .wr_sync  (bus_wdata[CTL_SYNC]),
        .wr_upd   (bus_wdata[CTL_UPD]),
        .wr_intl  (bus_wdata[CTL_INTL]),
        .run      (run),
        .sync_en  (sync_en),
        .upd      (upd),
        .intl     (intl),
        .idle     (idle),
        .vs_rise  (vs_rise),
        .xfer     (xfer),
        .evt_pend (evt_pend)
    );

    vsb_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .vs_rise    (vs_rise),
        .wr_int     (wr_int),
        .wr_en_bit  (bus_wdata[IRQ_EN]),
        .wr_clr_bit (bus_wdata[IRQ_CLR]),
        .stat       (stat),
        .en         (en),
        .irq        (irq)
    );

    vsb_pairs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_pairs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_base     (wr_base),
        .wr_idx      (idx[IDX_W-1:0]),
        .wdata       (bus_wdata),
        .xfer        (xfer),
        .base_flat   (base_flat),
        .shadow_flat (shadow_o),
        .all_match   (all_match)
    );

    assign vblank_evt = evt_pend & (~intl | (all_match & ~upd));

    always_comb begin
        bus_rdata = '0;
        unique case (region)
            REGION_CSR: begin
                if (idx == CSR_CTRL) begin
                    bus_rdata[CTL_RUN]  = run;
                    bus_rdata[CTL_SYNC] = sync_en;
                    bus_rdata[CTL_UPD]  = upd;
                    bus_rdata[CTL_IDLE] = idle;
                    bus_rdata[CTL_INTL] = intl;
                end else if (idx == CSR_INT) begin
                    bus_rdata[IRQ_EN]   = en;
                    bus_rdata[IRQ_STAT] = stat;
                end
            end
            REGION_BASE:   if (idx_ok) bus_rdata = base_flat[idx[IDX_W-1:0]*DATA_W +: DATA_W];
            REGION_SHADOW: if (idx_ok) bus_rdata = shadow_o[idx[IDX_W-1:0]*DATA_W +: DATA_W];
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         vsync,
    input logic [W-1:0] shadow_o,
    input logic         irq,
    input logic         vblank_evt,
    input logic         xfer,
    input logic         vs_rise,
    input logic         upd,
    input logic         stat,
    input logic         en,
    input logic         run,
    input logic         idle,
    input logic         wr_ctrl,
    input logic         wr_int,
    input logic         wr_upd_bit,
    input logic         wr_clr_bit
);
    // R3
    shadow_only_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow_o) |-> $past(xfer));

    // R4
    upd_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !(wr_ctrl && wr_upd_bit)) |=> !upd);

    // R6
    stat_on_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> stat);

    // R6
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en && stat));

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_int && wr_clr_bit && !vs_rise) |=> !stat);

    // R8
    vblank_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_evt |-> $past(vs_rise));

    // R9
    run_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> !idle);

    // R8
    vblank_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_evt |=> !vblank_evt);

    logic unused_vsync;
    assign unused_vsync = vsync;
endmodule

bind vsync_shadow_bank vsb_checker #(.W(NUM_REGS*DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .shadow_o   (shadow_o),
    .irq        (irq),
    .vblank_evt (vblank_evt),
    .xfer       (xfer),
    .vs_rise    (vs_rise),
    .upd        (upd),
    .stat       (stat),
    .en         (en),
    .run        (run),
    .idle       (idle),
    .wr_ctrl    (wr_ctrl),
    .wr_int     (wr_int),
    .wr_upd_bit (bus_wdata[2]),
    .wr_clr_bit (bus_wdata[8])
);

// File: tb/vsync_shadow_bank_bench.sv
module vsync_shadow_bank_bench;
    localparam int N = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vsync = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N*DW-1:0] shadow_o;
    logic          irq;
    logic          vblank_evt;

    int errors = 0;
    int checks = 0;
    bit comparing = 1'b0;
    bit finished = 1'b0;
    int cycles = 0;

    always #5 clk = ~clk;

    vsync_shadow_bank #(.NUM_REGS(N), .DATA_W(DW)) u_vsync_shadow_bank (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shadow_o(shadow_o), .irq(irq), .vblank_evt(vblank_evt)
    );

    // behavioural reference
    logic [DW-1:0] m_base [N];
    logic [DW-1:0] m_shadow [N];
    bit m_run, m_sync, m_upd, m_intl, m_idle, m_vsp, m_pend, m_stat, m_en;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_base[i] = 0; m_shadow[i] = 0; end
            m_run = 0; m_sync = 0; m_upd = 0; m_intl = 0; m_idle = 1;
            m_vsp = 0; m_pend = 0; m_stat = 0; m_en = 0;
        end else begin
            bit rise, xf;
            rise = vsync && !m_vsp;
            xf = rise && m_sync && m_upd;
            if (xf) for (int i = 0; i < N; i++) m_shadow[i] = m_base[i];
            if (bus_wr && bus_addr[5:4] == 2'b01 && bus_addr[3:0] < N)
                m_base[bus_addr[1:0]] = bus_wdata;
            if (m_run) m_idle = 0; else if (rise) m_idle = 1;
            if (rise) m_stat = 1;
            else if (bus_wr && bus_addr == 6'h01 && bus_wdata[8]) m_stat = 0;
            if (bus_wr && bus_addr == 6'h01) m_en = bus_wdata[0];
            if (xf) m_upd = 0;
            if (bus_wr && bus_addr == 6'h00) begin
                m_run = bus_wdata[0]; m_sync = bus_wdata[1]; m_intl = bus_wdata[4];
                if (bus_wdata[2]) m_upd = 1;
            end
            m_pend = rise;
            m_vsp = vsync;
        end
    end

    function automatic logic [DW-1:0] m_read(input logic [5:0] a);
        logic [DW-1:0] v = '0;
        if (a == 6'h00) v = {27'd0, m_intl, m_idle, m_upd, m_sync, m_run};
        else if (a == 6'h01) v = {27'd0, m_stat, 3'd0, m_en};
        else if (a[5:4] == 2'b01 && a[3:0] < N) v = m_base[a[1:0]];
        else if (a[5:4] == 2'b10 && a[3:0] < N) v = m_shadow[a[1:0]];
        return v;
    endfunction

    function automatic string rd_tag(input logic [5:0] a);
        if (a == 6'h00) return "R9 ctrl read";
        if (a == 6'h01) return "R7 int read";
        if (a[5:4] == 2'b01 && a[3:0] < N) return "R2 base read";
        if (a[5:4] == 2'b10 && a[3:0] < N) return "R5 shadow read";
        return "R10 unmapped read";
    endfunction

    task automatic check(input string tag, input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing) begin
            logic [N*DW-1:0] exp_sh;
            bit match;
            match = 1;
            for (int i = 0; i < N; i++) begin
                exp_sh[i*DW +: DW] = m_shadow[i];
                if (m_shadow[i] != m_base[i]) match = 0;
            end
            check("R3 shadow outputs", shadow_o, exp_sh);
            check("R6 irq", {{(N*DW-1){1'b0}}, irq}, {{(N*DW-1){1'b0}}, m_stat & m_en});
            check("R8 vblank_evt", {{(N*DW-1){1'b0}}, vblank_evt},
                  {{(N*DW-1){1'b0}}, m_pend & (!m_intl | (match & !m_upd))});
            check(rd_tag(bus_addr), {{((N-1)*DW){1'b0}}, bus_rdata},
                  {{((N-1)*DW){1'b0}}, m_read(bus_addr)});
        end
    end

    task automatic cyc(input logic vs, input logic wr, input logic [5:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        #1;
        vsync = vs; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [5:0] a);
        cyc(vsync, 1'b0, a, '0);
    endtask

    task automatic pulse_vs(input int hold);
        cyc(1'b1, 1'b0, 6'h00, '0);
        for (int k = 0; k < hold; k++) cyc(1'b1, 1'b0, 6'h00, '0);
        cyc(1'b0, 1'b0, 6'h00, '0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, literal expectations
        check("R1 reset ctrl", {{((N-1)*DW){1'b0}}, bus_rdata}, 'h8);
        check("R1 reset irq", {{(N*DW-1){1'b0}}, irq}, '0);
        check("R1 reset shadows", shadow_o, '0);
        comparing = 1'b1;

        // R2 base writes, shadows unchanged
        for (int i = 0; i < N; i++) cyc(1'b0, 1'b1, 6'h10 + 6'(i), 32'hA000_0000 + 32'(i));
        for (int i = 0; i < N; i++) begin rd(6'h10 + 6'(i)); rd(6'h20 + 6'(i)); end

        // R3 vsync with sync off: no transfer; R6 status sets with enable 0
        pulse_vs(2);
        rd(6'h01);
        cyc(1'b0, 1'b1, 6'h01, 32'h1);   // R6 enable -> irq high
        rd(6'h01);
        // R7 clear coincident with vsync edge: status stays
        cyc(1'b1, 1'b1, 6'h01, 32'h101);
        cyc(1'b0, 1'b0, 6'h01, '0);
        // R7 clear alone
        cyc(1'b0, 1'b1, 6'h01, 32'h101);
        rd(6'h01);

        // R4 request with sync off persists across vsync; write 0 keeps it
        cyc(1'b0, 1'b1, 6'h00, 32'h04);
        pulse_vs(1);
        cyc(1'b0, 1'b1, 6'h00, 32'h00);
        rd(6'h00);
        // R3 R4 enable sync: transfer clears request
        cyc(1'b0, 1'b1, 6'h00, 32'h06);
        pulse_vs(1);
        for (int i = 0; i < N; i++) rd(6'h20 + 6'(i));
        rd(6'h00);

        // R5 base write in the transfer cycle
        cyc(1'b0, 1'b1, 6'h00, 32'h06);
        cyc(1'b1, 1'b1, 6'h11, 32'h5555_1111);
        cyc(1'b0, 1'b0, 6'h21, '0);
        rd(6'h11);
        cyc(1'b0, 1'b1, 6'h00, 32'h06);
        pulse_vs(0);
        rd(6'h21);

        // R8 interlaced, mismatch with sync off -> no event
        cyc(1'b0, 1'b1, 6'h00, 32'h10);
        cyc(1'b0, 1'b1, 6'h12, 32'hDEAD_BEEF);
        pulse_vs(1);
        // R8 interlaced with transfer -> event
        cyc(1'b0, 1'b1, 6'h00, 32'h16);
        pulse_vs(1);
        // R8 progressive always pulses
        cyc(1'b0, 1'b1, 6'h13, 32'h1234_5678);
        cyc(1'b0, 1'b1, 6'h00, 32'h00);
        pulse_vs(1);

        // R9 run / idle
        cyc(1'b0, 1'b1, 6'h00, 32'h01);
        rd(6'h00); rd(6'h00);
        cyc(1'b0, 1'b1, 6'h00, 32'h00);
        rd(6'h00);
        pulse_vs(1);
        rd(6'h00);

        // R10 unmapped reads, ignored writes
        rd(6'h3F); rd(6'h05); rd(6'h14); rd(6'h2F);
        cyc(1'b0, 1'b1, 6'h20, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b1, 6'h3A, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b1, 6'h15, 32'hFFFF_FFFF);
        rd(6'h20); rd(6'h00); rd(6'h01);

        // random collisions
        for (int n = 0; n < 600; n++) begin
            logic [5:0] a;
            int sel;
            sel = int'($urandom_range(0, 5));
            case (sel)
                0: a = 6'h00;
                1: a = 6'h01;
                2: a = 6'h10 + 6'($urandom_range(0, N-1));
                3: a = 6'h20 + 6'($urandom_range(0, N-1));
                4: a = 6'($urandom);
                default: a = 6'h10 + 6'($urandom_range(0, N-1));
            endcase
            cyc(($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1), a, $urandom);
        end
        cyc(1'b0, 1'b0, 6'h00, '0);
        @(negedge clk);
        comparing = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule